// File: doc/BRIEF.md
# Addressable Bit Latch Array

This block stores eight single bits in level-sensitive latches. A binary select picks one latch, and a shared data bit reaches it only while an active-low write enable is held low. Eight parallel outputs of true polarity show what the latches hold. The block can serve as a small working register, or as a serial-to-parallel holding register that takes one bit per address. It can also act as an active-high 1-of-8 demultiplexer.

An active-low clear combines with the write enable to give four modes:

| Write enable | Clear | Mode |
|---|---|---|
| high | high | memory (hold) |
| low | high | addressable latch |
| low | low | demultiplexer |
| high | low | clear |

The clear is asynchronous. It empties the array outright only while the write enable is high. While the write enable is low, the clear instead turns the array into a pure demultiplexer.

Top module: `addr_latch_array`

## Requirements
- R1: Memory mode (le_ni=1, rst_ni=1): no output changes, whatever sel_i and d_i do.
- R2: Addressable-latch mode (le_ni=0, rst_ni=1): the addressed output equals d_i, and the other seven outputs keep their stored values.
- R3: Demultiplexer mode (le_ni=0, rst_ni=0): the addressed output equals d_i, and the other seven outputs are 0.
- R4: Clear mode (le_ni=1, rst_ni=0): all eight outputs are 0. This takes effect at once, with no clock.
- R5: Releasing the clear while le_ni=1 leaves all outputs at 0 until the next write.
- R6: sel_i is binary-weighted: a select value k addresses q_o[k]. In demultiplexer mode at most one output is high.
- R7: While le_ni stays low, the addressed output follows every later change of d_i (it is transparent, not edge-captured). When le_ni rises, the output keeps the last value of d_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 3 | Binary select of the target latch |
| d_i | input | 1 | Shared data bit |
| le_ni | input | 1 | Write enable, active low, level-sensitive |
| rst_ni | input | 1 | Asynchronous clear, active low |
| q_o | output | 8 | Stored bits, true polarity |

## Verification
A wrong stored bit shows on its own output line as soon as it is stored, because no register stands between the latches and the ports. A latch written through a wrong decode shows up as a change on an unaddressed line during a write. The fault stays visible on that line until a later write or a clear repairs it. The bench therefore compares all eight outputs after every change of the inputs. It walks address sequences in which a stray write or a lost hold would leave a mismatch behind.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_e;

  function automatic mode_e mode_of(input logic le_n, input logic clr_n);
    case ({le_n, clr_n})
      2'b11:   return MODE_HOLD;
      2'b01:   return MODE_WRITE;
      2'b00:   return MODE_DEMUX;
      default: return MODE_CLEAR;
    endcase
  endfunction
endpackage

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hit_o
);
  for (genvar k = 0; k < N; k++) begin : g_hit
    assign hit_o[k] = (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/latch_cell.sv
module latch_cell
  import addr_latch_pkg::*;
(
  input  mode_e mode_i,
  input  logic  hit_i,
  input  logic  d_i,
  output logic  q_o
);
  logic zero, wr;

  always_comb begin
    zero = (mode_i == MODE_CLEAR) || (mode_i == MODE_DEMUX && !hit_i);
    wr   = hit_i && (mode_i == MODE_WRITE || mode_i == MODE_DEMUX);
  end

  always_latch begin
    if (zero)    q_o <= 1'b0;
    else if (wr) q_o <= d_i;
  end
endmodule

// File: rtl/addr_latch_array.sv
module addr_latch_array
  import addr_latch_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             d_i,
  input  logic             le_ni,
  input  logic             rst_ni,
  output logic [N-1:0]     q_o
);
  mode_e        mode;
  logic [N-1:0] hit;

  assign mode = mode_of(le_ni, rst_ni);

  sel_decode #(.SEL_W(SEL_W)) u_dec (.sel_i(sel_i), .hit_o(hit));

  for (genvar k = 0; k < N; k++) begin : g_cell
    latch_cell u_cell (
      .mode_i(mode),
      .hit_i (hit[k]),
      .d_i   (d_i),
      .q_o   (q_o[k])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input logic [SEL_W-1:0] sel_i,
  input logic             d_i,
  input logic             le_ni,
  input logic             rst_ni,
  input logic [N-1:0]     q_o
);
  always_comb begin
    if (le_ni && !rst_ni) begin
      // R4
      clear_zero_chk: assert (q_o == '0);
    end
    if (!le_ni && !rst_ni) begin
      // R3
      demux_sel_chk: assert (q_o[sel_i] == d_i);
      // R6
      demux_onehot_chk: assert ($countones(q_o) <= 1);
    end
    if (!le_ni && rst_ni) begin
      // R2
      write_follow_chk: assert (q_o[sel_i] == d_i);
    end
  end

  always @(q_o) begin
    if ($time > 0) begin
      // R1
      hold_stable_chk: assert (!(le_ni && rst_ni));
    end
  end
endmodule

bind addr_latch_array addr_latch_chk #(.SEL_W(SEL_W)) u_chk (
  .sel_i (sel_i),
  .d_i   (d_i),
  .le_ni (le_ni),
  .rst_ni(rst_ni),
  .q_o   (q_o)
);

// File: tb/sim_addr_latch_array.sv
module sim_addr_latch_array;
  logic       clk = 1'b0;
  logic [2:0] sel_i = '0;
  logic       d_i = 1'b0;
  logic       le_ni = 1'b1;
  logic       rst_ni = 1'b0;
  logic [7:0] q_o;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  addr_latch_array u0 (.sel_i(sel_i), .d_i(d_i), .le_ni(le_ni), .rst_ni(rst_ni), .q_o(q_o));

  // {le_n, clr_n, sel, d, expected q}
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd0, 1'b0, 8'h00},  // R5 released clear, zeros
    {1'b0, 1'b1, 3'd0, 1'b1, 8'h01},  // R2
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h09},  // R2 R6
    {1'b0, 1'b1, 3'd7, 1'b1, 8'h89},  // R2 R6
    {1'b0, 1'b1, 3'd0, 1'b0, 8'h88},  // R2
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h88},  // R1
    {1'b1, 1'b1, 3'd2, 1'b0, 8'h88},  // R1
    {1'b0, 1'b1, 3'd6, 1'b1, 8'hC8},  // R2
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},  // R3
    {1'b0, 1'b0, 3'd2, 1'b0, 8'h00},  // R3
    {1'b0, 1'b0, 3'd7, 1'b1, 8'h80},  // R3
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h00},  // R4
    {1'b1, 1'b1, 3'd4, 1'b1, 8'h00},  // R5
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h10},  // R2
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h12},  // R2
    {1'b1, 1'b1, 3'd1, 1'b0, 8'h12}   // R1 R7
  };

  task automatic check(input logic [7:0] exp, input string req);
    n_vec++;
    if (q_o !== exp) begin
      n_bad++;
      $display("FAIL %s: q_o=%h expected %h", req, q_o, exp);
    end
  endtask

  // enable edge is kept apart from select/data changes
  task automatic apply(input logic le, input logic clr, input logic [2:0] s, input logic d);
    @(posedge clk);
    if (le) begin
      le_ni = 1'b1; #1; rst_ni = clr; sel_i = s; d_i = d;
    end else begin
      rst_ni = clr; sel_i = s; d_i = d; #1; le_ni = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(8'h00, "R4 reset state");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      check(VEC[i][7:0], $sformatf("vector %0d R1/R2/R3/R4/R5", i));
    end

    // R6 decode sweep in demultiplexer mode
    for (int k = 0; k < 8; k++) begin
      apply(1'b0, 1'b0, 3'(k), 1'b1);
      check(8'(1 << k), "R6 demux one-hot");
      apply(1'b0, 1'b0, 3'(k), 1'b0);
      check(8'h00, "R3 demux data low");
    end

    // R7 transparency: data toggles with enable held low
    apply(1'b1, 1'b1, 3'd5, 1'b0);
    apply(1'b0, 1'b1, 3'd5, 1'b1);
    check(8'h20, "R7 transparent high");
    @(posedge clk); d_i = 1'b0; @(negedge clk);
    check(8'h00, "R7 transparent low");
    @(posedge clk); d_i = 1'b1; @(negedge clk);
    check(8'h20, "R7 transparent high again");
    apply(1'b1, 1'b1, 3'd5, 1'b1);
    check(8'h20, "R7 held after enable rise");
    apply(1'b1, 1'b1, 3'd5, 1'b0);
    check(8'h20, "R1 data ignored in memory mode");

    // R2 fill all ones serially, then clear mid-cycle
    for (int k = 0; k < 8; k++) apply(1'b0, 1'b1, 3'(k), 1'b1);
    apply(1'b1, 1'b1, 3'd0, 1'b0);
    check(8'hFF, "R2 serial fill");
    #1 rst_ni = 1'b0; #0.5;
    check(8'h00, "R4 asynchronous clear");
    apply(1'b1, 1'b1, 3'd3, 1'b1);
    check(8'h00, "R5 zeros after clear release");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule